// File: doc/BRIEF.md
# Bus Data-Float Wait-State Controller

This block decides when the next access on a shared external static-memory bus may begin after a read. A slow device keeps driving the data bus for a programmable number of cycles once its read ends. The controller keeps a single countdown of that remaining float time. It grants a pending access only when the countdown allows it, and it signals busy on each idle turnaround cycle that it inserts.

Each chip select has its own settings:
- a float length;
- an optimization enable bit;
- a read hold length;
- a read setup length;
- a write setup length.

The hold phase of the finished read always overlaps the float time. When optimization is enabled and the next access targets the same chip select, that access's setup phase also overlaps the float time. Only the part of the float time that no overlap covers becomes wait states. When a write follows a read, at least one direction-change cycle is inserted. The external sequencer raises `rd_done` on the last cycle of every read, which is the end of its hold phase. It then holds `req` high until `grant` is returned.

Top module: `float_wait_ctrl`

## Requirements
- R1: `grant` is high exactly when `req` is high and no wait is required. `busy` is high exactly on the cycles where `req` is high and `grant` is low. The two are never high together.
- R2: On a cycle with `rd_done` high, the remaining float time becomes the float length minus the read hold of chip select `rd_done_cs`, clamped at zero. When the hold is greater than or equal to the float length, the next access gets no float wait states.
- R3: The remaining float time drops by one on every cycle without `rd_done` until it reaches zero. Once it is zero, a read request is granted on its first cycle.
- R4: When the optimization bit of the last read's chip select is 1 and the request targets that same chip select, the request's setup length (write setup if `req_wr`=1, read setup otherwise) is credited. The number of float wait cycles is then the remaining float time at the first request cycle minus that setup, clamped at zero.
- R5: When the optimization bit is 0, a request to the same chip select waits for the entire remaining float time.
- R6: A request to a chip select other than the last read's waits for the entire remaining float time, whatever the optimization bit is.
- R7: A write requested after a read, with no grant in between, waits at least one cycle. Its wait count is the larger of 1 and the float wait count.
- R8: A float length of 0 produces no float wait states.
- R9: A new `rd_done` reloads the remaining float time and the chip-select reference from the new read, replacing any earlier pending value.
- R10: Reset (`rst_n` low) clears any pending float time and any pending direction change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until granted |
| req_wr | input | 1 | 1 = requested access is a write |
| req_cs | input | CSW | Chip select of the requested access |
| rd_done | input | 1 | Last cycle of a read (end of hold) |
| rd_done_cs | input | CSW | Chip select of the finishing read |
| cfg_float_len | input | NCS*CW | Float length per chip select |
| cfg_float_opt | input | NCS | Float optimization enable per chip select |
| cfg_rd_hold | input | NCS*CW | Read hold length per chip select |
| cfg_rd_setup | input | NCS*CW | Read setup length per chip select |
| cfg_wr_setup | input | NCS*CW | Write setup length per chip select |
| grant | output | 1 | Access may start this cycle |
| busy | output | 1 | Inserted wait cycle |

## Verification
The assertions check several properties on every cycle:
- grant and busy are never high together;
- the float counter counts down one step per cycle;
- a read requested after the counter has expired is granted at once;
- a request to a different chip select is held while float time remains;
- a write directly after a read always waits;
- a zero float length or a hold that covers the float length leaves nothing pending.

Exact wait counts can only be shown by the bench's scenarios. These cover the setup credit on the same chip select, the full wait under optimization off, the reload by a second read, and the clearing by reset. The bench also checks the reference case of hold 4, setup 3 and float 6, which needs no float wait but still gets its single turnaround cycle.

// File: rtl/float_wait_ctrl.sv
module float_wait_ctrl #(
  parameter int NCS = 4,
  parameter int CW  = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [CSW-1:0]    req_cs,
  input  logic              rd_done,
  input  logic [CSW-1:0]    rd_done_cs,
  input  logic [NCS*CW-1:0] cfg_float_len,
  input  logic [NCS-1:0]    cfg_float_opt,
  input  logic [NCS*CW-1:0] cfg_rd_hold,
  input  logic [NCS*CW-1:0] cfg_rd_setup,
  input  logic [NCS*CW-1:0] cfg_wr_setup,
  output logic              grant,
  output logic              busy
);

  logic [CW-1:0]  cnt;
  logic [CSW-1:0] last_cs;
  logic           dir_rd;

  logic [CW-1:0] done_len, done_hold, rem;
  logic [CW-1:0] setup, credit;
  logic          float_blk, turn_blk;

  assign done_len  = cfg_float_len[rd_done_cs*CW +: CW];
  assign done_hold = cfg_rd_hold[rd_done_cs*CW +: CW];
  assign rem       = (done_len > done_hold) ? done_len - done_hold : '0;

  assign setup  = req_wr ? cfg_wr_setup[req_cs*CW +: CW] : cfg_rd_setup[req_cs*CW +: CW];
  assign credit = (req_cs == last_cs && cfg_float_opt[last_cs]) ? setup : '0;

  assign float_blk = cnt > credit;
  assign turn_blk  = req_wr && dir_rd;
  assign busy      = req && (float_blk || turn_blk);
  assign grant     = req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      last_cs <= '0;
      dir_rd  <= 1'b0;
    end else if (rd_done) begin
      cnt     <= rem;
      last_cs <= rd_done_cs;
      dir_rd  <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (req) dir_rd <= 1'b0;
    end
  end

  AST_GRANT_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && busy)); // R1
  AST_HOLD_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && (done_hold >= done_len) |=> cnt == '0); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R3
  AST_EXPIRED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    req && !req_wr && cnt == '0 |-> grant); // R3
  AST_OTHER_CS_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    req && req_cs != last_cs && cnt != '0 |-> busy); // R6
  AST_RD_TO_WR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_done) && req && req_wr |-> busy); // R7
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && done_len == '0 |=> cnt == '0); // R8

endmodule

// File: tb/float_wait_ctrl_tb.sv
module float_wait_ctrl_tb;
  localparam int CLK = 10;
  localparam int NCS = 4;
  localparam int CW  = 4;
  localparam int CSW = 2;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0, rd_done = 0;
  logic [CSW-1:0] req_cs = '0, rd_done_cs = '0;
  logic [NCS*CW-1:0] cfg_float_len = '0, cfg_rd_hold = '0, cfg_rd_setup = '0, cfg_wr_setup = '0;
  logic [NCS-1:0] cfg_float_opt = '0;
  logic grant, busy;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK/2) clk = ~clk;

  float_wait_ctrl #(.NCS(NCS), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_cs(req_cs),
    .rd_done(rd_done), .rd_done_cs(rd_done_cs),
    .cfg_float_len(cfg_float_len), .cfg_float_opt(cfg_float_opt),
    .cfg_rd_hold(cfg_rd_hold), .cfg_rd_setup(cfg_rd_setup), .cfg_wr_setup(cfg_wr_setup),
    .grant(grant), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cs(input int cs, input int len, input int hold, input bit opt,
                        input int rs, input int ws);
    cfg_float_len[cs*CW +: CW] = len[CW-1:0];
    cfg_rd_hold[cs*CW +: CW]   = hold[CW-1:0];
    cfg_float_opt[cs]          = opt;
    cfg_rd_setup[cs*CW +: CW]  = rs[CW-1:0];
    cfg_wr_setup[cs*CW +: CW]  = ws[CW-1:0];
  endtask

  function automatic int exp_waits(input int len, input int hold, input bit opt, input int setup,
                                   input bit same, input int gap, input bit wr);
    int r, c, cred, w;
    r = (len > hold) ? len - hold : 0;
    c = (r > gap) ? r - gap : 0;
    cred = (same && opt) ? setup : 0;
    w = (c > cred) ? c - cred : 0;
    if (wr && w < 1) w = 1;
    return w;
  endfunction

  task automatic end_read(input int cs);
    @(negedge clk);
    rd_done = 1; rd_done_cs = cs[CSW-1:0];
    @(negedge clk);
    rd_done = 0;
  endtask

  task automatic access(input bit wr, input int cs, input int gap, output int waits);
    repeat (gap) @(negedge clk);
    req = 1; req_wr = wr; req_cs = cs[CSW-1:0];
    waits = 0;
    #1;
    while (!grant && waits < 40) begin
      if (busy) waits++;
      @(negedge clk); #1;
    end
    chk(grant && !busy, "R1 grant/busy at grant cycle", busy, 0);
    @(negedge clk);
    req = 0;
  endtask

  task automatic scenario(input int rcs, input int ncs, input bit wr, input int gap, input string tag);
    int w, e, len, hold, setup;
    bit opt;
    len = int'(cfg_float_len[rcs*CW +: CW]);
    hold = int'(cfg_rd_hold[rcs*CW +: CW]);
    opt = cfg_float_opt[rcs];
    setup = wr ? int'(cfg_wr_setup[ncs*CW +: CW]) : int'(cfg_rd_setup[ncs*CW +: CW]);
    end_read(rcs);
    access(wr, ncs, gap, w);
    e = exp_waits(len, hold, opt, setup, rcs == ncs, gap, wr);
    chk(w == e, tag, w, e);
  endtask

  initial begin
    #(CLK*150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int w, seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    #1;
    chk(grant == 0 && busy == 0, "R1 reset outputs", {grant, busy}, 0);
    rst_n = 1;
    access(0, 0, 0, w);
    chk(w == 0, "R10 no waits after reset", w, 0);

    set_cs(0, 6, 4, 1, 1, 3);
    scenario(0, 0, 1, 0, "R4 same-cs write reference case (turnaround only)");
    set_cs(1, 9, 2, 1, 2, 3);
    scenario(1, 1, 1, 0, "R4 same-cs write setup credit");
    scenario(1, 1, 0, 0, "R4 same-cs read setup credit");
    set_cs(2, 9, 2, 0, 2, 3);
    scenario(2, 2, 0, 0, "R5 opt off same cs read");
    scenario(2, 2, 1, 0, "R5 opt off same cs write");
    scenario(1, 3, 0, 0, "R6 other cs read full waits");
    scenario(1, 0, 1, 0, "R6 other cs write full waits");
    set_cs(3, 5, 7, 0, 0, 0);
    scenario(3, 0, 0, 0, "R2 hold covers float");
    scenario(1, 2, 0, 20, "R3 expired float");
    set_cs(3, 0, 0, 0, 0, 0);
    scenario(3, 3, 0, 0, "R8 zero float length read");
    scenario(3, 3, 1, 0, "R7 write after read, zero float");
    scenario(1, 2, 1, 3, "R7 write after read with partial float");

    set_cs(0, 15, 0, 0, 0, 0);
    set_cs(2, 3, 0, 0, 0, 0);
    end_read(0);
    end_read(2);
    access(0, 1, 0, w);
    chk(w == 3, "R9 reload by newer read", w, 3);

    end_read(0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    access(1, 1, 0, w);
    chk(w == 0, "R10 reset clears float and turnaround", w, 0);

    for (int i = 0; i < 60; i++) begin
      int rc, nc, g;
      bit wr;
      for (int c = 0; c < NCS; c++)
        set_cs(c, $urandom_range(0, 15), $urandom_range(0, 6), 1'($urandom_range(0, 1)),
               $urandom_range(0, 6), $urandom_range(0, 6));
      rc = $urandom_range(0, NCS-1);
      nc = ($urandom_range(0, 1) == 1) ? rc : $urandom_range(0, NCS-1);
      wr = 1'($urandom_range(0, 1));
      g = $urandom_range(0, 4);
      scenario(rc, nc, wr, g, "R4 R5 R6 R7 random transition");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule